// File: doc/BRIEF.md
# Fan PWM Duty Generator with Minimum-Speed Floor

This block drives a fan switch with a fixed-frequency pulse-width-modulated signal. A free-running ramp counter splits time into periods of `PERIOD` clock steps. Two 8-bit codes come in: a temperature code and a minimum-speed (floor) code. At each period boundary the block takes the larger of the two, scales it linearly onto the period, and holds that on-time for the whole of the next period. The output is high for the first N steps of the period and low for the rest.

The block raises a non-latching over-temperature flag whenever the temperature code is above the full-scale level. The flag is only a warning, and the fan keeps running. A supervisor can ask for full drive with a force-on request. It can also stop the fan at once with a shutdown request, which overrides everything else. The block emits a one-cycle strobe in the last step of every period. Other blocks use this strobe as the timebase for their start-up, diagnostic and missing-pulse timers.

Top module: `fan_pwm_floor`

## Requirements
- R1: The ramp counter starts at step 0 when reset is released. It counts 0..PERIOD-1 and wraps. `period_tick_o` is high for exactly one clock, in step PERIOD-1 of every period, and low in every other step.
- R2: While reset is high, and in the first period after reset, `pwm_o` is low. `over_temp_o` and `period_tick_o` are also low during reset.
- R3: The code that sets the duty is the larger of `temp_code_i` and `floor_code_i`.
- R4: For a selected code c below FULL_CODE, the output is high in steps 0..N-1 of the period and low in the remaining steps, with N = floor(c * PERIOD / FULL_CODE).
- R5: A selected code at or above FULL_CODE gives an output that is high in every step of the period. A selected code of 0 gives an output that is low in every step.
- R6: The codes and the force-on request are sampled only on the clock edge that ends a period, which is the step where `period_tick_o` is high. Any change in the middle of a period has no effect on `pwm_o` until the next period.
- R7: `over_temp_o` goes high one clock after `temp_code_i` rises above FULL_CODE. It goes low one clock after `temp_code_i` drops to FULL_CODE or below. It is held low while `shutdown_i` is high.
- R8: A high `over_temp_o` never stops the PWM. A temperature code above FULL_CODE still drives the output high for the whole period.
- R9: While `shutdown_i` is high, `pwm_o` is low in the same cycle. This holds whatever the codes and the force-on request are.
- R10: If `force_on_i` is high at the period boundary, `pwm_o` is high for every step of the following period, unless shutdown is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| temp_code_i | input | CODE_W | Duty code from the temperature measurement |
| floor_code_i | input | CODE_W | Minimum-speed duty code |
| force_on_i | input | 1 | Supervisor request for full drive, sampled per period |
| shutdown_i | input | 1 | Supervisor stop, takes effect immediately |
| pwm_o | output | 1 | Fan drive |
| period_tick_o | output | 1 | One-clock strobe in the last step of each period |
| over_temp_o | output | 1 | Temperature code above full scale |

## Verification
The bench uses a small configuration: a period of 10 steps and a full-scale code of 40. It sweeps each code across the whole range around full scale while the other code sits low. It then walks a grid of code pairs. In each period it compares the output step by step with the computed on-time. A design that chose the wrong code, rounded the on-time the wrong way, or failed to saturate above full scale would show highs in the wrong steps. Separate tests change a code and the force-on request in the middle of a period, which catches a design that resamples early. They also raise shutdown while force-on is active, and step the temperature code across the flag threshold in both directions, which catches off-by-one comparisons and a flag that latches.

// File: rtl/fan_pwm_pkg.sv
package fan_pwm_pkg;

    typedef enum logic [1:0] {
        DRV_OFF  = 2'd0,
        DRV_PWM  = 2'd1,
        DRV_FULL = 2'd2
    } drive_mode_e;

    // number of high steps in one period for a given code
    function automatic int unsigned on_steps(input int unsigned code,
                                             input int unsigned full,
                                             input int unsigned period);
        if (code >= full)
            return period;
        return (code * period) / full;
    endfunction

    function automatic int unsigned larger(input int unsigned a,
                                           input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/fan_pwm_ramp.sv
module fan_pwm_ramp #(
    parameter int PERIOD = 256
) (
    input  logic                       clk,
    input  logic                       rst,
    output logic [$clog2(PERIOD)-1:0]  step_o,
    output logic                       tick_o
);
    localparam int CNT_W = $clog2(PERIOD);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (cnt_q == LAST)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    assign step_o = cnt_q;
    assign tick_o = (cnt_q == LAST) && !rst;

    // R1: a strobe is followed by the first step of a new period
    p_wrap_to_zero_r1: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> (step_o == '0));

    // R1: never two strobes back to back
    p_single_strobe_r1: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> !tick_o);

endmodule

// File: rtl/fan_pwm_select.sv
module fan_pwm_select
    import fan_pwm_pkg::*;
#(
    parameter int CODE_W    = 8,
    parameter int PERIOD    = 256,
    parameter int FULL_CODE = 200
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          tick_i,
    input  logic [CODE_W-1:0]             temp_code_i,
    input  logic [CODE_W-1:0]             floor_code_i,
    input  logic                          force_on_i,
    output logic [$clog2(PERIOD+1)-1:0]   duty_o,
    output drive_mode_e                   mode_o
);
    localparam int DUTY_W = $clog2(PERIOD + 1);

    logic [DUTY_W-1:0] duty_next;
    drive_mode_e       mode_next;
    logic [DUTY_W-1:0] duty_q;
    drive_mode_e       mode_q;

    always_comb begin
        duty_next = DUTY_W'(on_steps(larger(32'(temp_code_i), 32'(floor_code_i)),
                                     FULL_CODE, PERIOD));
        if (force_on_i)
            mode_next = DRV_FULL;
        else if (duty_next == '0)
            mode_next = DRV_OFF;
        else
            mode_next = DRV_PWM;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            duty_q <= '0;
            mode_q <= DRV_OFF;
        end else if (tick_i) begin
            duty_q <= duty_next;
            mode_q <= mode_next;
        end
    end

    assign duty_o = duty_q;
    assign mode_o = mode_q;

    // R6: the period settings hold between boundaries
    p_hold_mid_period_r6: assert property (@(posedge clk) disable iff (rst)
        !tick_i |=> ($stable(duty_q) && $stable(mode_q)));

    // R10: force sampled at the boundary selects full drive
    p_force_latched_r10: assert property (@(posedge clk) disable iff (rst)
        (tick_i && force_on_i) |=> (mode_q == DRV_FULL));

endmodule

// File: rtl/fan_pwm_otf.sv
module fan_pwm_otf #(
    parameter int CODE_W    = 8,
    parameter int FULL_CODE = 200
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] temp_code_i,
    input  logic              shutdown_i,
    output logic              flag_o
);
    logic flag_q;

    always_ff @(posedge clk) begin
        if (rst)
            flag_q <= 1'b0;
        else
            flag_q <= !shutdown_i && (32'(temp_code_i) > FULL_CODE);
    end

    assign flag_o = flag_q;

    // R7: over-range sets the flag on the next clock
    p_otf_set_r7: assert property (@(posedge clk) disable iff (rst)
        (!shutdown_i && (32'(temp_code_i) > FULL_CODE)) |=> flag_o);

    // R7: back in range clears it on the next clock
    p_otf_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (32'(temp_code_i) <= FULL_CODE) |=> !flag_o);

endmodule

// File: rtl/fan_pwm_floor.sv
module fan_pwm_floor
    import fan_pwm_pkg::*;
#(
    parameter int CODE_W    = 8,
    parameter int PERIOD    = 256,
    parameter int FULL_CODE = 200
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] temp_code_i,
    input  logic [CODE_W-1:0] floor_code_i,
    input  logic              force_on_i,
    input  logic              shutdown_i,
    output logic              pwm_o,
    output logic              period_tick_o,
    output logic              over_temp_o
);
    localparam int CNT_W  = $clog2(PERIOD);
    localparam int DUTY_W = $clog2(PERIOD + 1);

    logic [CNT_W-1:0]  step;
    logic              tick;
    logic [DUTY_W-1:0] duty;
    drive_mode_e       mode;

    fan_pwm_ramp #(.PERIOD(PERIOD)) u_ramp (
        .clk    (clk),
        .rst    (rst),
        .step_o (step),
        .tick_o (tick)
    );

    fan_pwm_select #(
        .CODE_W    (CODE_W),
        .PERIOD    (PERIOD),
        .FULL_CODE (FULL_CODE)
    ) u_select (
        .clk          (clk),
        .rst          (rst),
        .tick_i       (tick),
        .temp_code_i  (temp_code_i),
        .floor_code_i (floor_code_i),
        .force_on_i   (force_on_i),
        .duty_o       (duty),
        .mode_o       (mode)
    );

    fan_pwm_otf #(
        .CODE_W    (CODE_W),
        .FULL_CODE (FULL_CODE)
    ) u_otf (
        .clk         (clk),
        .rst         (rst),
        .temp_code_i (temp_code_i),
        .shutdown_i  (shutdown_i),
        .flag_o      (over_temp_o)
    );

    logic drive;
    always_comb begin
        unique case (mode)
            DRV_FULL: drive = 1'b1;
            DRV_PWM:  drive = (DUTY_W'(step) < duty);
            default:  drive = 1'b0;
        endcase
    end

    assign pwm_o         = drive && !shutdown_i && !rst;
    assign period_tick_o = tick;

    // R5: both codes at zero on the boundary give a dark period start
    p_zero_code_r5: assert property (@(posedge clk) disable iff (rst)
        (tick && temp_code_i == '0 && floor_code_i == '0 && !force_on_i) |=> !pwm_o);

    // R5, R8: a saturated code drives the first step high unless shut down
    p_full_code_r5: assert property (@(posedge clk) disable iff (rst)
        (tick && (32'(temp_code_i) >= FULL_CODE || 32'(floor_code_i) >= FULL_CODE))
        |=> (pwm_o || shutdown_i));

    // R10: forced period starts high unless shut down
    p_force_high_r10: assert property (@(posedge clk) disable iff (rst)
        (tick && force_on_i) |=> (pwm_o || shutdown_i));

    // R9: shutdown wins over every other input
    p_shutdown_off_r9: assert property (@(posedge clk) disable iff (rst)
        shutdown_i |-> !pwm_o);

endmodule

// File: tb/tb_fan_pwm_floor.sv
module tb_fan_pwm_floor;
    localparam int CLK_PERIOD = 10;
    localparam int P    = 10;
    localparam int FULL = 40;
    localparam int CW   = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [CW-1:0] temp_code = '0;
    logic [CW-1:0] floor_code = '0;
    logic          force_on = 1'b0;
    logic          shutdown = 1'b0;
    logic          pwm, tick, otf;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    fan_pwm_floor #(.CODE_W(CW), .PERIOD(P), .FULL_CODE(FULL)) dut (
        .clk           (clk),
        .rst           (rst),
        .temp_code_i   (temp_code),
        .floor_code_i  (floor_code),
        .force_on_i    (force_on),
        .shutdown_i    (shutdown),
        .pwm_o         (pwm),
        .period_tick_o (tick),
        .over_temp_o   (otf)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int exp_on(input int t, input int m);
        int c;
        c = (t > m) ? t : m;
        if (c >= FULL) return P;
        return (c * P) / FULL;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic wait_tick();
        do @(negedge clk); while (!tick);
    endtask

    // called at a tick negedge; checks the following period step by step
    task automatic measure(input int expn, input string req);
        int bad_pwm, bad_tick, highs;
        bad_pwm = 0; bad_tick = 0; highs = 0;
        for (int k = 0; k < P; k++) begin
            @(negedge clk);
            if (pwm) highs++;
            if (pwm != (k < expn)) bad_pwm++;
            if (tick != (k == P - 1)) bad_tick++;
        end
        check(bad_pwm == 0, req, highs, expn);
        check(bad_tick == 0, "R1", bad_tick, 0);
    endtask

    initial begin
        int cyc = 0;
        while (!done && cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int cnt;
        // R2: reset state
        temp_code = 8'd60; force_on = 1'b1;
        repeat (3) @(negedge clk);
        check(pwm == 1'b0 && otf == 1'b0 && tick == 1'b0, "R2", {pwm, otf, tick}, 0);
        rst = 1'b0;
        // R1, R2: first strobe P-1 cycles after release, output dark before it
        cnt = 0;
        while (!tick) begin
            check(pwm == 1'b0, "R2", pwm, 0);
            @(negedge clk);
            cnt++;
        end
        check(cnt == P - 1, "R1", cnt, P - 1);
        force_on = 1'b0; temp_code = '0;

        // R4, R5, R8: temperature code sweep with floor at zero
        for (int t = 0; t < 64; t++) begin
            temp_code = CW'(t);
            measure(exp_on(t, 0), (t >= FULL) ? "R8" : ((t == 0) ? "R5" : "R4"));
        end
        // R3, R5: floor code sweep with low temperature
        for (int m = 0; m < 64; m++) begin
            temp_code = 8'd7; floor_code = CW'(m);
            measure(exp_on(7, m), (m >= FULL) ? "R5" : "R3");
        end
        // R3: grid of pairs
        for (int t = 0; t <= 45; t += 5)
            for (int m = 0; m <= 45; m += 5) begin
                temp_code = CW'(t); floor_code = CW'(m);
                measure(exp_on(t, m), "R3");
            end

        // R6: mid-period code change has no effect until next period
        temp_code = 8'd20; floor_code = '0;
        begin
            int bad = 0;
            for (int k = 0; k < P; k++) begin
                @(negedge clk);
                if (k == 2) begin temp_code = 8'd40; floor_code = 8'd40; end
                if (pwm != (k < exp_on(20, 0))) bad++;
            end
            check(bad == 0, "R6", bad, 0);
        end
        measure(P, "R6");
        // R6, R10: force raised mid-period waits for the boundary
        temp_code = '0; floor_code = '0;
        begin
            int bad = 0;
            for (int k = 0; k < P; k++) begin
                @(negedge clk);
                if (k == 3) force_on = 1'b1;
                if (pwm != 1'b0) bad++;
            end
            check(bad == 0, "R6", bad, 0);
        end
        measure(P, "R10");
        measure(P, "R10");
        force_on = 1'b0;
        measure(0, "R10");

        // R9: shutdown forces output low immediately, over force and full code
        force_on = 1'b1; temp_code = 8'd255;
        measure(P, "R10");
        @(negedge clk); @(negedge clk);
        shutdown = 1'b1;
        #1 check(pwm == 1'b0, "R9", pwm, 0);
        wait_tick();
        measure(0, "R9");
        // R7: flag held low in shutdown
        check(otf == 1'b0, "R7", otf, 0);
        shutdown = 1'b0; force_on = 1'b0;
        @(negedge clk);
        check(otf == 1'b1, "R7", otf, 1);
        wait_tick();
        // R7: threshold steps in both directions
        temp_code = CW'(FULL);
        @(negedge clk);
        check(otf == 1'b0, "R7", otf, 0);
        temp_code = CW'(FULL + 1);
        @(negedge clk);
        check(otf == 1'b1, "R7", otf, 1);
        temp_code = CW'(FULL);
        @(negedge clk);
        check(otf == 1'b0, "R7", otf, 0);
        // R8: flag high while fan runs at full drive
        temp_code = 8'd200;
        wait_tick();
        measure(P, "R8");
        check(otf == 1'b1, "R8", otf, 1);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule